// File: doc/BRIEF.md
# Averaging Four-Slot Conversion Sequencer

This block sits in front of one 12-bit converter core and shares it among four conversion slots, numbered 0 to 3. Each slot has its own enable, its own analog input select and its own averaging setting. It also chooses between a one-shot run and a continuous run. The sequencer visits the enabled slots in rotation. For the slot it is serving, it issues one start pulse per sample, sums the returned samples and divides the sum by a power of two. It then posts the 12-bit average into a result word that two slots share, and it raises a completion status bit for that slot.

If a converter does not answer within a programmable number of cycles, the slot is marked with a timeout bit and is skipped for this turn. Software can stop a slot at any moment by clearing its enable. The sample in progress is then dropped and no result is posted. Registers are reached through a simple one-cycle write strobe and a combinational read port.

The controller has four states:

| State | Role |
| --- | --- |
| IDLE | Picks the next enabled slot |
| START | Pulses the start request |
| WAIT | Waits for the converter |
| POST | Writes the average |

Its transitions are:

- IDLE→START when some slot is enabled.
- START→WAIT always.
- WAIT→START on a sample that is not the last one.
- WAIT→POST on the last sample.
- WAIT→IDLE on an abort or a timeout.
- POST→IDLE always.

Top module: `adc_slot_sequencer`

## Requirements
- R1: After reset, every slot config word, both result words and the status word read 0, the timeout limit reads 1024, and `conv_start` and `irq` are low.
- R2: Config word 1 of slot n is at address n*0x20. It holds enable at bit 31, one-shot at bit 30, averaging enable at bit 29 and the input select at bits 27:24. Config word 2 of slot n is at n*0x20+0x10 and holds the averaging code at bits 13:12. The written fields read back.
- R3: Each sample is requested by a `conv_start` pulse exactly one cycle long, with `conv_sel` equal to the serving slot's input select.
- R4: With averaging enabled, code c takes 4<<c samples and the result is their sum shifted right by 2+c. With averaging disabled, one sample is taken, it is posted unchanged, and the code is ignored.
- R5: Slots 0 and 1 post into the word at 0xF0, and slots 2 and 3 post into the word at 0x100. The even slot uses bits 11:0 and the odd slot uses bits 27:16. Posting one field leaves the other field unchanged, and every other bit reads 0.
- R6: Posting slot n sets status bit 8+n in the status word at 0xC0. Writing 1 to a status bit clears it. `irq` is high while any status bit is set.
- R7: A one-shot slot clears its own enable after posting and keeps its other fields. A continuous slot stays enabled and keeps converting.
- R8: Enabled slots are served in the rotating order 0,1,2,3, one averaged result per turn.
- R9: When `conv_done` does not arrive within the limit held at 0x84 (bits 15:0), timeout status bit 16+n is set. No result and no completion bit are posted, and the sequencer moves on.
- R10: Clearing a slot's enable while it waits for a sample aborts it. Nothing is posted, no status bit is set, and no further start is issued for that slot.
- R11: A `conv_done` that arrives while no sample is pending changes no result or status.

## Ports
| Port | Direction | Width | Description |
| --- | --- | --- | --- |
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 9 | Register byte address for reads and writes |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| conv_start | output | 1 | One-cycle request for one converter sample |
| conv_sel | output | 4 | Analog input select for the requested sample |
| conv_done | input | 1 | Converter sample valid pulse |
| conv_data | input | 12 | Converter sample value |
| irq | output | 1 | High while any status bit is set |

## Verification
A wrong sample counter or shift amount shows up as an average that differs from the arithmetic mean. It also shows up as a start count other than 4<<c, both visible when the completion bit rises a few hundred cycles later. A wrong slot pointer shows up at the next start pulse: either `conv_sel` breaks the rotation, or the result lands in the wrong half-word. A stuck timer or a missed abort shows up as a missing timeout bit, a spurious completion bit, or starts that continue after the enable is cleared. Each of these is visible within a few tens of cycles.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
    typedef enum logic [1:0] {S_IDLE, S_START, S_WAIT, S_POST} seq_state_t;

    localparam int BIT_EN      = 31;
    localparam int BIT_ONESHOT = 30;
    localparam int BIT_AVG     = 29;
    localparam int SEL_LSB     = 24;
    localparam int CODE_LSB    = 12;
    localparam int SLOT_STRIDE = 32;
    localparam int CFG2_OFS    = 16;
    localparam int RES_BASE    = 240;
    localparam int RES_STRIDE  = 16;
    localparam int ODD_LSB     = 16;
    localparam int STAT_ADDR   = 192;
    localparam int TMO_ADDR    = 132;
    localparam int DONE_LSB    = 8;
    localparam int TMO_LSB     = 16;
endpackage

// File: rtl/adc_seq_rr_pick.sv
module adc_seq_rr_pick #(
    parameter int NSLOT = 4,
    parameter int IW    = 2
) (
    input  logic [NSLOT-1:0] req,
    input  logic [IW-1:0]    last,
    output logic             found,
    output logic [IW-1:0]    pick
);
    int idx;
    always_comb begin
        found = 1'b0;
        pick  = last;
        idx   = 0;
        for (int k = 1; k <= NSLOT; k++) begin
            idx = (int'(last) + k) % NSLOT;
            if (!found && req[idx]) begin
                found = 1'b1;
                pick  = IW'(idx);
            end
        end
    end
endmodule

// File: rtl/adc_seq_accum.sv
module adc_seq_accum #(
    parameter int DW    = 12,
    parameter int ACC_W = 17,
    parameter int SHW   = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic           add,
    input  logic [DW-1:0]  din,
    input  logic [SHW-1:0] shift,
    output logic [DW-1:0]  avg
);
    logic [ACC_W-1:0] acc_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   acc_q <= '0;
        else if (clr) acc_q <= '0;
        else if (add) acc_q <= acc_q + ACC_W'(din);
    end
    assign avg = DW'(acc_q >> shift);
endmodule

// File: rtl/adc_slot_sequencer.sv
module adc_slot_sequencer
    import adc_seq_pkg::*;
#(
    parameter int NSLOT       = 4,
    parameter int DW          = 12,
    parameter int SEL_W       = 4,
    parameter int AW          = 9,
    parameter int TMR_W       = 16,
    parameter int TMO_DEFAULT = 1024,
    parameter int CODE_W      = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [AW-1:0]    reg_addr,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      reg_rdata,
    output logic             conv_start,
    output logic [SEL_W-1:0] conv_sel,
    input  logic             conv_done,
    input  logic [DW-1:0]    conv_data,
    output logic             irq
);
    localparam int IW      = $clog2(NSLOT);
    localparam int MAX_AVG = 4 << ((1 << CODE_W) - 1);
    localparam int ACC_W   = DW + $clog2(MAX_AVG);
    localparam int SCNT_W  = $clog2(MAX_AVG) + 1;
    localparam int SHW     = $clog2($clog2(MAX_AVG) + 1);
    localparam int NRES    = NSLOT / 2;

    seq_state_t state, state_nx;

    logic [NSLOT-1:0]  en_q, oneshot_q, avg_q, done_st, tmo_st;
    logic [SEL_W-1:0]  sel_q  [NSLOT];
    logic [CODE_W-1:0] code_q [NSLOT];
    logic [DW-1:0]     res_q  [NSLOT];
    logic [TMR_W-1:0]  tmo_limit, tmr;
    logic [SCNT_W-1:0] samp_cnt, samp_need;
    logic [SHW-1:0]    shift;
    logic [IW-1:0]     cur, pick;
    logic              found, en_cur, last_samp, tmo_hit, acc_add;
    logic [DW-1:0]     avg;
    logic              wdata_unused;

    assign wdata_unused = ^reg_wdata;

    adc_seq_rr_pick #(.NSLOT(NSLOT), .IW(IW)) u_pick (
        .req(en_q), .last(cur), .found(found), .pick(pick)
    );

    assign en_cur    = en_q[cur];
    assign samp_need = avg_q[cur] ? (SCNT_W'(4) << code_q[cur]) : SCNT_W'(1);
    assign shift     = avg_q[cur] ? (SHW'(2) + SHW'(code_q[cur])) : SHW'(0);
    assign last_samp = (samp_cnt + SCNT_W'(1)) == samp_need;
    assign tmo_hit   = (state == S_WAIT) && en_cur && !conv_done
                       && (tmr == tmo_limit - TMR_W'(1));
    assign acc_add   = (state == S_WAIT) && en_cur && conv_done;

    adc_seq_accum #(.DW(DW), .ACC_W(ACC_W), .SHW(SHW)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(state == S_IDLE), .add(acc_add),
        .din(conv_data), .shift(shift), .avg(avg)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            S_IDLE:  if (found) state_nx = S_START;
            S_START: state_nx = S_WAIT;
            S_WAIT: begin
                if (!en_cur)        state_nx = S_IDLE;
                else if (conv_done) state_nx = last_samp ? S_POST : S_START;
                else if (tmo_hit)   state_nx = S_IDLE;
            end
            S_POST:  state_nx = S_IDLE;
        endcase
    end

    assign conv_start = (state == S_START);
    assign conv_sel   = sel_q[cur];
    assign irq        = |{done_st, tmo_st};

    // datapath and registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0; oneshot_q <= '0; avg_q <= '0;
            done_st <= '0; tmo_st <= '0;
            tmo_limit <= TMR_W'(TMO_DEFAULT);
            tmr <= '0; samp_cnt <= '0;
            cur <= IW'(NSLOT - 1);
            for (int n = 0; n < NSLOT; n++) begin
                sel_q[n] <= '0; code_q[n] <= '0; res_q[n] <= '0;
            end
        end else begin
            unique case (state)
                S_IDLE:  if (found) begin cur <= pick; samp_cnt <= '0; end
                S_START: tmr <= '0;
                S_WAIT: begin
                    tmr <= tmr + TMR_W'(1);
                    if (acc_add) samp_cnt <= samp_cnt + SCNT_W'(1);
                end
                S_POST: ;
            endcase
            for (int n = 0; n < NSLOT; n++) begin
                if (reg_we && reg_addr == AW'(STAT_ADDR)) begin
                    if (reg_wdata[DONE_LSB + n]) done_st[n] <= 1'b0;
                    if (reg_wdata[TMO_LSB + n])  tmo_st[n]  <= 1'b0;
                end
                if (cur == IW'(n)) begin
                    if (tmo_hit) tmo_st[n] <= 1'b1;
                    if (state == S_POST) begin
                        res_q[n]   <= avg;
                        done_st[n] <= 1'b1;
                        if (oneshot_q[n]) en_q[n] <= 1'b0;
                    end
                end
                if (reg_we && reg_addr == AW'(n * SLOT_STRIDE)) begin
                    en_q[n]      <= reg_wdata[BIT_EN];
                    oneshot_q[n] <= reg_wdata[BIT_ONESHOT];
                    avg_q[n]     <= reg_wdata[BIT_AVG];
                    sel_q[n]     <= reg_wdata[SEL_LSB +: SEL_W];
                end
                if (reg_we && reg_addr == AW'(n * SLOT_STRIDE + CFG2_OFS))
                    code_q[n] <= reg_wdata[CODE_LSB +: CODE_W];
            end
            if (reg_we && reg_addr == AW'(TMO_ADDR))
                tmo_limit <= reg_wdata[TMR_W-1:0];
        end
    end

    // read mux
    always_comb begin
        reg_rdata = '0;
        for (int n = 0; n < NSLOT; n++) begin
            if (reg_addr == AW'(n * SLOT_STRIDE)) begin
                reg_rdata[BIT_EN]             = en_q[n];
                reg_rdata[BIT_ONESHOT]        = oneshot_q[n];
                reg_rdata[BIT_AVG]            = avg_q[n];
                reg_rdata[SEL_LSB +: SEL_W]   = sel_q[n];
            end
            if (reg_addr == AW'(n * SLOT_STRIDE + CFG2_OFS))
                reg_rdata[CODE_LSB +: CODE_W] = code_q[n];
        end
        for (int k = 0; k < NRES; k++) begin
            if (reg_addr == AW'(RES_BASE + k * RES_STRIDE)) begin
                reg_rdata[DW-1:0]        = res_q[2*k];
                reg_rdata[ODD_LSB +: DW] = res_q[2*k+1];
            end
        end
        if (reg_addr == AW'(STAT_ADDR)) begin
            reg_rdata[DONE_LSB +: NSLOT] = done_st;
            reg_rdata[TMO_LSB +: NSLOT]  = tmo_st;
        end
        if (reg_addr == AW'(TMO_ADDR))
            reg_rdata[TMR_W-1:0] = tmo_limit;
    end
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk
    import adc_seq_pkg::*;
#(
    parameter int NSLOT  = 4,
    parameter int IW     = 2,
    parameter int TMR_W  = 16,
    parameter int SCNT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              conv_start,
    input logic              reg_we,
    input seq_state_t        state,
    input logic [IW-1:0]     cur,
    input logic [NSLOT-1:0]  en_q,
    input logic [NSLOT-1:0]  oneshot_q,
    input logic [TMR_W-1:0]  tmr,
    input logic [TMR_W-1:0]  tmo_limit,
    input logic [SCNT_W-1:0] samp_cnt,
    input logic [SCNT_W-1:0] samp_need
);
    // R3
    start_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> !conv_start);
    // R3
    start_then_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_start |=> state == S_WAIT);
    // R4
    samp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state != S_IDLE) |-> samp_cnt <= samp_need);
    // R9
    tmr_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && tmo_limit != '0) |-> tmr < tmo_limit);
    // R10
    abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_WAIT && !en_q[cur]) |=> state == S_IDLE);
    // R7
    oneshot_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_POST && oneshot_q[cur] && !reg_we) |=> !en_q[cur]);
endmodule

bind adc_slot_sequencer adc_seq_chk #(
    .NSLOT(NSLOT), .IW(IW), .TMR_W(TMR_W), .SCNT_W(SCNT_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .conv_start(conv_start), .reg_we(reg_we),
    .state(state), .cur(cur), .en_q(en_q), .oneshot_q(oneshot_q),
    .tmr(tmr), .tmo_limit(tmo_limit), .samp_cnt(samp_cnt), .samp_need(samp_need)
);

// File: tb/adc_slot_sequencer_tb.sv
module adc_slot_sequencer_tb;
    logic        clk = 0, rst_n = 0;
    logic        reg_we = 0;
    logic [8:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic [31:0] reg_rdata;
    logic        conv_start, conv_done = 0, irq;
    logic [3:0]  conv_sel;
    logic [11:0] conv_data = 0;

    int checks = 0, fails = 0;
    int stub_lat = 1, stub_cnt = 0, kidx = 0, nstart = 0;
    bit stub_mute = 0;
    int sel_lat = 0;
    int log_sel [0:4095];
    int exp_res [0:3];

    always #10 clk = ~clk;

    adc_slot_sequencer u_dut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .conv_start(conv_start),
        .conv_sel(conv_sel), .conv_done(conv_done), .conv_data(conv_data), .irq(irq)
    );

    function automatic int samp(int s, int k);
        return (s * 397 + k * 1237 + 55) & 'hFFF;
    endfunction

    function automatic int exp_avg(int s, int n, int sh);
        int sum = 0;
        for (int k = 0; k < n; k++) sum += samp(s, k);
        return sum >> sh;
    endfunction

    // behavioural converter stub
    always @(negedge clk) begin
        conv_done = 0;
        if (stub_cnt != 0) begin
            stub_cnt = stub_cnt - 1;
            if (stub_cnt == 0 && !stub_mute) begin
                conv_done = 1;
                conv_data = 12'(samp(sel_lat, kidx));
                kidx = kidx + 1;
            end
        end
        if (conv_start) begin
            stub_cnt = stub_lat;
            sel_lat  = int'(conv_sel);
            if (nstart < 4096) log_sel[nstart] = int'(conv_sel);
            nstart = nstart + 1;
        end
    end

    task automatic chk(input string tag, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = 9'(a); reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = 9'(a);
        #1 d = reg_rdata;
    endtask

    task automatic wait_stat(input int b, input int maxc, output bit ok);
        logic [31:0] v;
        ok = 0;
        for (int i = 0; i < maxc && !ok; i++) begin
            rd('hC0, v);
            if (v[b]) ok = 1;
        end
    endtask

    function automatic logic [31:0] cfg1(bit en, bit os, bit av, int sel);
        return {en, os, av, 1'b0, 4'(sel), 24'h0};
    endfunction

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        logic [31:0] v;
        bit ok;
        int base, n_smp, sh, exp_next;
        for (int i = 0; i < 4; i++) exp_res[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        for (int n = 0; n < 4; n++) begin
            rd(n * 32, v);      chk("R1 cfg1 reset", v, 0);
            rd(n * 32 + 16, v); chk("R1 cfg2 reset", v, 0);
        end
        rd('hF0, v);  chk("R1 result01 reset", v, 0);
        rd('h100, v); chk("R1 result23 reset", v, 0);
        rd('hC0, v);  chk("R1 status reset", v, 0);
        rd('h84, v);  chk("R1 limit reset", v, 1024);
        chk("R1 conv_start reset", conv_start, 0);
        chk("R1 irq reset", irq, 0);

        // R2 readback of fields (disabled slot)
        wr(0, cfg1(0, 1, 1, 9));
        rd(0, v); chk("R2 cfg1 readback", v, cfg1(0, 1, 1, 9));
        wr(16, 32'h0000_3000);
        rd(16, v); chk("R2 cfg2 readback", v, 32'h0000_3000);

        // Sweep: every slot, every code, averaging on and off (R3 R4 R5 R6 R7)
        for (int av = 1; av >= 0; av--) begin
            for (int n = 0; n < 4; n++) begin
                for (int c = 0; c < 4; c++) begin
                    if (av == 0 && c != 3) continue;
                    n_smp = av ? (4 << c) : 1;
                    sh    = av ? (2 + c) : 0;
                    kidx = 0; base = nstart;
                    wr(n * 32 + 16, 32'(c) << 12);
                    wr(n * 32, cfg1(1, 1, av[0], n + 4 + c));
                    wait_stat(8 + n, 3000, ok);
                    chk("R6 completion bit", ok, 1);
                    chk("R6 irq high", irq, 1);
                    exp_res[n] = exp_avg(n + 4 + c, n_smp, sh);
                    rd('hF0 + (n / 2) * 16, v);
                    chk("R4 average", (n % 2) ? v[27:16] : v[11:0], exp_res[n]);
                    chk("R5 sibling field", (n % 2) ? v[11:0] : v[27:16],
                        exp_res[n ^ 1]);
                    chk("R5 spare bits", {v[31:28], v[15:12]}, 0);
                    chk("R3 start count", nstart - base, n_smp);
                    for (int i = base; i < nstart; i++)
                        chk("R3 conv_sel", log_sel[i], n + 4 + c);
                    rd(n * 32, v);
                    chk("R7 one-shot enable cleared", v, cfg1(0, 1, av[0], n + 4 + c));
                    wr('hC0, 32'h000F_0F00);
                    rd('hC0, v); chk("R6 status cleared", v, 0);
                    chk("R6 irq low", irq, 0);
                end
            end
        end

        // R8 rotation with continuous slots 1..3, input select equal to slot index
        kidx = 0;
        for (int n = 1; n < 4; n++) wr(n * 32, cfg1(1, 0, 0, n));
        base = nstart;
        for (int i = 0; i < 500 && nstart < base + 14; i++) @(negedge clk);
        rd(32, v); chk("R7 continuous stays enabled", v[31], 1);
        for (int i = base + 4; i < base + 13; i++) begin
            exp_next = (log_sel[i-1] == 3) ? 1 : log_sel[i-1] + 1;
            chk("R8 rotation order", log_sel[i], exp_next);
        end
        for (int n = 1; n < 4; n++) wr(n * 32, 0);
        repeat (5) @(negedge clk);
        base = nstart;
        repeat (30) @(negedge clk);
        chk("R10 no starts after disable", nstart - base, 0);
        wr('hC0, 32'h000F_0F00);
        for (int n = 0; n < 4; n++) exp_res[n] = 0;
        rd('hF0, v);  exp_res[0] = v[11:0]; exp_res[1] = v[27:16];
        rd('h100, v); exp_res[2] = v[11:0]; exp_res[3] = v[27:16];

        // R9 timeout on slot 2
        wr('h84, 20);
        rd('h84, v); chk("R9 limit readback", v, 20);
        stub_mute = 1;
        wr(2 * 32, cfg1(1, 1, 0, 7));
        wait_stat(18, 100, ok);
        chk("R9 timeout bit", ok, 1);
        wr(2 * 32, 0);
        repeat (4) @(negedge clk);
        rd('hC0, v); chk("R9 no completion bit", v[15:8], 0);
        rd('h100, v); chk("R9 no result posted", v[11:0], exp_res[2]);
        stub_mute = 0;
        wr('hC0, 32'h000F_0F00);
        wr('h84, 1024);

        // R10 abort mid-sample, R11 late done ignored
        stub_lat = 30; kidx = 0; base = nstart;
        wr(3 * 32, cfg1(1, 1, 0, 5));
        for (int i = 0; i < 20 && nstart == base; i++) @(negedge clk);
        wr(3 * 32, 0);
        repeat (60) @(negedge clk);
        rd('hC0, v);  chk("R10 no status after abort", v, 0);
        rd('h100, v); chk("R11 late done ignored", v[27:16], exp_res[3]);
        chk("R10 single start", nstart - base, 1);
        stub_lat = 1;

        summary();
    end
endmodule